// File: doc/BRIEF.md
# SD Card Clock Control Unit

This unit derives the card clock for an SD host from the base clock, under control of a small register port. Software turns on the internal clock first. A stable flag follows a fixed number of base cycles later. Only after the flag is up does software open the gate that lets the clock reach the card. An 8-bit divisor field N sets the card clock to base/(2N). A value of 0 passes the base clock straight through.

A self-clearing software reset returns the unit's control state to zero. The block also holds a data timeout counter whose length is set by a 4-bit exponent. Other blocks of the host use a one-cycle strobe, which marks every base cycle in which the card clock has a rising edge, so they can advance their logic in step with the card.

Register map (addressed by `reg_addr_i`, read data is combinational on the same address):
- address 0, clock control: [15:8] divisor N, [2] card clock enable, [1] stable flag (read-only), [0] internal clock enable.
- address 1, timeout control: [3:0] exponent e.
- address 2, software reset: [0] reset request and busy flag.

Top module: `sd_clk_ctrl`

## Requirements
- R1: After `rst_ni` is deasserted, all three registers read zero, `sd_clk_o` is low and `dto_expired_o` is low.
- R2: The stable flag (address 0 bit 1) reads 1 from the 8th rising edge after the edge that writes internal enable to 1. It reads 0 in the same cycle that internal enable is written to 0.
- R3: The card clock toggles only while the card clock enable bit and the stable flag are both 1. If the enable is set before the flag, the clock stays low until the flag rises.
- R4: For N ≥ 1 the card clock has a period of 2N base cycles, high for N and low for N. Its first rising edge comes N base cycles after the edge that starts it.
- R5: With N = 0 the card clock is the base clock itself, gated by the enables, with gating changes taking effect at a falling base edge.
- R6: `sd_clk_stb_o` is high for exactly the base cycles in which the card clock has just risen: one cycle per card period for N ≥ 1, every cycle with N = 0.
- R7: A write to address 0 while card clock enable reads 1 leaves the divisor field unchanged. The enable bits are still updated.
- R8: Clearing the card clock enable lets a high phase that is in progress complete, and then holds the card clock low.
- R9: Writing 1 to address 2 bit 0 makes that bit read 1 for RST_CYC (default 4) cycles, after which it clears itself. The write clears the clock control and timeout control registers, and writes to any register during the busy window are ignored.
- R10: A pulse on `dto_start_i` makes `dto_expired_o` rise 2^(TO_BASE+e) base cycles later, where e is limited to at most 14 (TO_BASE default 13, so e = 14 gives 2^27). The output then stays high until `dto_stop_i` or a new start. A stop pulse clears the output and halts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| dto_start_i | input | 1 | Start or restart the data timeout count |
| dto_stop_i | input | 1 | Stop the count and clear the expiry flag |
| dto_expired_o | output | 1 | Data timeout expired |
| sd_clk_o | output | 1 | Card clock |
| sd_clk_stb_o | output | 1 | Card clock rising-edge strobe in base clock domain |

## Verification
Register writes take effect at the edge that samples them. The stable flag follows 8 edges later. A divided clock rises N edges after the gate opens, and the timeout flag rises 2^(TO_BASE+e) edges after the start edge. The bench drives inputs on falling edges and samples 1 ns after each rising edge. At each sample it compares every output with a behavioural model that is advanced on the same edge. The directed checks count those samples and compare the counts with the cycle numbers in the requirements. For N = 0 the bench also samples in the low half of the base clock.

// File: rtl/sdcc_pkg.sv
package sdcc_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned EXP_W = 4;
  localparam int unsigned EXP_MAX = 14;

  typedef enum logic [1:0] {
    ADDR_CLK  = 2'd0,
    ADDR_DTO  = 2'd1,
    ADDR_SRST = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/sdcc_stab.sv
module sdcc_stab #(
  parameter int unsigned STABLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic stable_o
);
  localparam int unsigned CW = $clog2(STABLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!en_i)                     cnt_q <= '0;
    else if (cnt_q != CW'(STABLE_CYC))  cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = en_i && (cnt_q == CW'(STABLE_CYC));

  // R2: stable only after enable was already held
  a_r2_stable_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable_o |-> $past(en_i));
endmodule

// File: rtl/sdcc_div.sv
module sdcc_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sd_clk_o,
  output logic             stb_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q, rise_q, gate_nq;
  logic             bypass;

  assign bypass = (div_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; clk_q <= 1'b0; rise_q <= 1'b0;
    end else if (clr_i || bypass) begin
      cnt_q <= '0; clk_q <= 1'b0; rise_q <= 1'b0;
    end else if (run_i || clk_q) begin
      // an open high phase always completes before stopping
      if (cnt_q >= div_i - 1'b1) begin
        cnt_q  <= '0;
        clk_q  <= ~clk_q;
        rise_q <= ~clk_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        rise_q <= 1'b0;
      end
    end else begin
      cnt_q <= '0; rise_q <= 1'b0;
    end
  end

  // bypass gate changes only while the base clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_nq <= 1'b0;
    else         gate_nq <= run_i;
  end

  assign sd_clk_o = bypass ? (clk_i & gate_nq) : clk_q;
  assign stb_o    = bypass ? gate_nq : rise_q;

  // R8: idle low divider stays low
  a_r8_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clk_q) |=> !clk_q);
  // R6: strobe only in a high card-clock cycle
  a_r6_stb_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass && rise_q) |-> clk_q);
  // R4: divided clock never rises twice in consecutive cycles
  a_r4_no_double_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |=> !rise_q);
endmodule

// File: rtl/sdcc_dto.sv
module sdcc_dto #(
  parameter int unsigned TO_BASE = 13,
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             expired_o
);
  localparam int unsigned CW = TO_BASE + EXP_MAX + 1;

  logic [CW-1:0] cnt_q, last_cnt;
  logic          active_q, expired_q;
  int unsigned   shift;

  always_comb begin
    shift    = TO_BASE + ((int'(exp_i) > EXP_MAX) ? EXP_MAX : int'(exp_i));
    last_cnt = (CW'(1) << shift) - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; active_q <= 1'b0; expired_q <= 1'b0;
    end else if (clr_i || stop_i) begin
      cnt_q <= '0; active_q <= 1'b0; expired_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0; active_q <= 1'b1; expired_q <= 1'b0;
    end else if (active_q) begin
      if (cnt_q == last_cnt) begin
        active_q  <= 1'b0;
        expired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign expired_o = expired_q;

  // R10: expiry and counting are exclusive
  a_r10_expired_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_q |-> !active_q);
  // R10: stop always clears the flag
  a_r10_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !expired_q);
endmodule

// File: rtl/sd_clk_ctrl.sv
module sd_clk_ctrl
  import sdcc_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 8,
  parameter int unsigned RST_CYC    = 4,
  parameter int unsigned TO_BASE    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             dto_start_i,
  input  logic             dto_stop_i,
  output logic             dto_expired_o,
  output logic             sd_clk_o,
  output logic             sd_clk_stb_o
);
  localparam int unsigned RCW = $clog2(RST_CYC + 1);

  logic             int_en_q, sd_en_q, busy_q, stable, run;
  logic [DIV_W-1:0] div_q;
  logic [EXP_W-1:0] exp_q;
  logic [RCW-1:0]   rcnt_q;
  logic             wr_ok, soft_start, soft_clr;
  reg_addr_e        addr;

  assign addr       = reg_addr_e'(reg_addr_i);
  assign wr_ok      = reg_we_i && !busy_q;
  assign soft_start = wr_ok && (addr == ADDR_SRST) && reg_wdata_i[0];
  assign soft_clr   = soft_start || busy_q;
  assign run        = sd_en_q && stable;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= 1'b0; sd_en_q <= 1'b0; div_q <= '0; exp_q <= '0;
    end else if (soft_clr) begin
      int_en_q <= 1'b0; sd_en_q <= 1'b0; div_q <= '0; exp_q <= '0;
    end else begin
      if (wr_ok && addr == ADDR_CLK) begin
        int_en_q <= reg_wdata_i[0];
        sd_en_q  <= reg_wdata_i[2];
        if (!sd_en_q) div_q <= reg_wdata_i[15:8];
      end
      if (wr_ok && addr == ADDR_DTO) exp_q <= reg_wdata_i[EXP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; rcnt_q <= '0;
    end else if (soft_start) begin
      busy_q <= 1'b1; rcnt_q <= '0;
    end else if (busy_q) begin
      if (rcnt_q == RCW'(RST_CYC - 1)) busy_q <= 1'b0;
      else                             rcnt_q <= rcnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CLK:  reg_rdata_o = {div_q, 5'b0, sd_en_q, stable, int_en_q};
      ADDR_DTO:  reg_rdata_o = {{(REG_W-EXP_W){1'b0}}, exp_q};
      ADDR_SRST: reg_rdata_o = {{(REG_W-1){1'b0}}, busy_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  sdcc_stab #(.STABLE_CYC(STABLE_CYC)) u_stab (
    .clk_i, .rst_ni, .en_i(int_en_q), .stable_o(stable)
  );

  sdcc_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .clr_i(soft_clr), .run_i(run), .div_i(div_q),
    .sd_clk_o, .stb_o(sd_clk_stb_o)
  );

  sdcc_dto #(.TO_BASE(TO_BASE), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_dto (
    .clk_i, .rst_ni, .clr_i(soft_clr), .start_i(dto_start_i),
    .stop_i(dto_stop_i), .exp_i(exp_q), .expired_o(dto_expired_o)
  );

  // R7: divisor frozen while card clock enabled
  a_r7_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_en_q && !soft_clr) |=> $stable(div_q));
  // R9: control state is zero after a busy cycle
  a_r9_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!int_en_q && !sd_en_q && div_q == '0 && exp_q == '0));
  // R9: busy bit clears itself
  a_r9_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rcnt_q == RCW'(RST_CYC - 1)) |=> !busy_q);
  // R3: divided card clock cannot start without stable
  a_r3_needs_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_clk_stb_o) && div_q != '0 |-> $past(stable));
endmodule

// File: tb/sd_clk_ctrl_bench.sv
`timescale 1ns/1ps
module sd_clk_ctrl_bench;
  localparam int TB_TO_BASE = 2;
  localparam int STAB = 8;
  localparam int RSTC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, start = 1'b0, stop = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic expired, sd_clk, stb;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sd_clk_ctrl #(.STABLE_CYC(STAB), .RST_CYC(RSTC), .TO_BASE(TB_TO_BASE)) u_sd_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .dto_start_i(start),
    .dto_stop_i(stop), .dto_expired_o(expired), .sd_clk_o(sd_clk),
    .sd_clk_stb_o(stb)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_int, m_sd, m_div, m_exp, m_busy, m_rcnt, m_scnt;
  int m_clk, m_dcnt, m_rise, m_gate, m_act, m_tcnt, m_expd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_int = 0; m_sd = 0; m_div = 0; m_exp = 0; m_busy = 0; m_rcnt = 0; m_scnt = 0;
      m_clk = 0; m_dcnt = 0; m_rise = 0; m_act = 0; m_tcnt = 0; m_expd = 0;
    end else begin
      int o_int, o_sd, o_div, o_exp, o_busy, o_rcnt, o_scnt, o_clk, o_dcnt, o_act, o_tcnt;
      int run, sst, clr, e, lim;
      o_int = m_int; o_sd = m_sd; o_div = m_div; o_exp = m_exp; o_busy = m_busy;
      o_rcnt = m_rcnt; o_scnt = m_scnt; o_clk = m_clk; o_dcnt = m_dcnt;
      o_act = m_act; o_tcnt = m_tcnt;
      run = (o_sd != 0) && (o_int != 0) && (o_scnt == STAB);
      sst = (we && !o_busy && addr == 2 && wd[0]) ? 1 : 0;
      clr = sst || o_busy;
      if (clr) begin
        m_int = 0; m_sd = 0; m_div = 0; m_exp = 0;
      end else begin
        if (we && !o_busy && addr == 0) begin
          m_int = wd[0]; m_sd = wd[2];
          if (!o_sd) m_div = wd[15:8];
        end
        if (we && !o_busy && addr == 1) m_exp = wd[3:0];
      end
      if (sst) begin m_busy = 1; m_rcnt = 0; end
      else if (o_busy) begin
        if (o_rcnt == RSTC - 1) m_busy = 0; else m_rcnt = o_rcnt + 1;
      end
      if (!o_int) m_scnt = 0; else if (o_scnt != STAB) m_scnt = o_scnt + 1;
      if (clr || o_div == 0) begin m_clk = 0; m_dcnt = 0; m_rise = 0; end
      else if (run || o_clk) begin
        if (o_dcnt >= o_div - 1) begin m_dcnt = 0; m_clk = !o_clk; m_rise = !o_clk; end
        else begin m_dcnt = o_dcnt + 1; m_rise = 0; end
      end else begin m_dcnt = 0; m_rise = 0; end
      e = (o_exp > 14) ? 14 : o_exp;
      lim = 1 << (TB_TO_BASE + e);
      if (clr || stop) begin m_act = 0; m_tcnt = 0; m_expd = 0; end
      else if (start) begin m_act = 1; m_tcnt = 0; m_expd = 0; end
      else if (o_act) begin
        if (o_tcnt == lim - 1) begin m_act = 0; m_expd = 1; end
        else m_tcnt = o_tcnt + 1;
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_gate = 0;
    else m_gate = ((m_sd != 0) && (m_int != 0) && (m_scnt == STAB)) ? 1 : 0;
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (!done) begin
      int exp_rd;
      case (addr)
        2'd0: exp_rd = (m_div << 8) | (m_sd << 2) |
                       ((m_int != 0 && m_scnt == STAB) ? 2 : 0) | m_int;
        2'd1: exp_rd = m_exp;
        2'd2: exp_rd = m_busy;
        default: exp_rd = 0;
      endcase
      chk("R2 rdata", rdata, exp_rd);
      chk("R4 sd_clk", sd_clk, (m_div == 0) ? m_gate : m_clk);
      chk("R6 stb", stb, (m_div == 0) ? m_gate : m_rise);
      chk("R10 expired", expired, m_expd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a;
    @(posedge clk); #1 v = rdata;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_expire(output int n);
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      @(posedge clk); #1 n++;
      if (expired) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, h, s;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    @(posedge clk); #1;
    chk("R1 clk reg", rdata, 0); chk("R1 sd_clk", sd_clk, 0); chk("R1 expired", expired, 0);
    rd(1, v); chk("R1 dto reg", v, 0);
    rd(2, v); chk("R1 srst reg", v, 0);
    @(negedge clk); addr = 0;

    // R2 stable 8 cycles after internal enable; R3 gate with sd_en set early
    wr(0, 16'h0405);
    n = 0; h = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 n++;
      if (rdata[1]) break;
      h += sd_clk;
    end
    chk("R2 stable delay", n, STAB);
    chk("R3 no clock before stable", h, 0);

    // R2 falls with enable, R4 restart timing and period
    wr(0, 16'h0400);
    #0.5 chk("R2 stable falls", rdata[1], 0);
    wr(0, 16'h0401);
    repeat (STAB + 1) @(posedge clk);
    wr(0, 16'h0405);
    n = 0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1 n++; if (stb) break; end
    chk("R4 first rise", n, 4);
    n = 0; h = 0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1 n++; h += sd_clk; if (stb) break; end
    chk("R4 period", n, 8);
    chk("R4 high half", h, 4);

    // R7 divisor write ignored while enabled
    wr(0, 16'h0205);
    rd(0, v);
    chk("R7 div kept", v[15:8], 4);
    chk("R7 enable kept", v[2], 1);

    // R8 gate off completes then stays low
    wr(0, 16'h0401);
    repeat (4) @(posedge clk);
    h = 0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1 h += sd_clk; end
    chk("R8 stays low", h, 0);

    // R6 strobe per period with N=1
    wr(0, 16'h0105);
    repeat (3) @(posedge clk);
    s = 0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1 s += stb; end
    chk("R6 strobe count", s, 10);

    // R5 bypass with N=0
    wr(0, 16'h0101);
    repeat (4) @(posedge clk);
    wr(0, 16'h0001);
    wr(0, 16'h0005);
    repeat (2) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk("R5 high phase", sd_clk, 1);
      chk("R6 bypass strobe", stb, 1);
      #2.5 chk("R5 low phase", sd_clk, 0);
    end

    // R9 software reset self-clears and clears state
    wr(1, 16'h0003);
    @(negedge clk); we = 1'b1; addr = 2; wd = 16'h0001;
    @(posedge clk); #1 n = rdata[0];
    @(negedge clk); we = 1'b0;
    for (int i = 0; i < 20; i++) begin @(posedge clk); #1; if (!rdata[0]) break; n++; end
    chk("R9 busy window", n, RSTC);
    rd(0, v); chk("R9 clk reg cleared", v, 0);
    rd(1, v); chk("R9 dto reg cleared", v, 0);
    wr(2, 16'h0001);
    wr(1, 16'h0007);
    repeat (RSTC + 2) @(posedge clk);
    rd(1, v); chk("R9 write ignored while busy", v, 0);

    // R10 timeout lengths, stop, clamp
    wr(1, 16'h0000);
    pulse_start(); wait_expire(n);
    chk("R10 e=0", n, 1 << TB_TO_BASE);
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0;
    #1 chk("R10 stop clears", expired, 0);
    wr(1, 16'h0003);
    pulse_start(); wait_expire(n);
    chk("R10 e=3", n, 1 << (TB_TO_BASE + 3));
    wr(1, 16'h000E);
    pulse_start(); wait_expire(n);
    chk("R10 e=14", n, 1 << (TB_TO_BASE + 14));
    wr(1, 16'h000F);
    pulse_start(); wait_expire(n);
    chk("R10 e=15 clamp", n, 1 << (TB_TO_BASE + 14));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule